// File: doc/BRIEF.md
# Serial-Frame 1-Wire Bus Master

This block runs a 1-Wire bus by sending one asynchronous serial frame for each bus slot. The frame format is one start bit, eight data bits sent least significant bit first, no parity and one stop bit. The bus timing therefore comes from baud-rate framing and not from counted software delays. A host issues one of four commands: bus reset with presence check, write byte, read byte or write single bit. The block then sends the frames, waits for each frame to be looped back, and reports the result.

The transmitter never drives the bus high. Its only output says whether the bus is pulled low; an external pull-up holds the line high otherwise. The shared line comes back on `bus_in` and feeds a 16x-oversampling receiver. The receiver and transmitter share one oversampling tick. The tick runs at a slow rate for the reset slot and at a fast rate for data slots, and the ratio of the two rates is set by the two divider parameters. The idle gap between slots is not timed, so the engine may pause between bits without harm.

Top module: `owfm_master`

## Requirements
- R1: Every slot is one frame of ten bit times: a low start bit, eight data bits LSB first, and a high stop bit. A data-0 slot therefore holds the bus low for exactly 9 fast bit times.
- R2: A reset command (`cmd_op`=0) sends the pattern 0xF0 at the slow rate. The bus is held low for 5 slow bit times (the start bit plus four zero bits), where one bit time is 16*DIV_SLOW clocks.
- R3: After a reset, `presence` is 1 when the looped-back frame differs from 0xF0 and 0 when it equals 0xF0. It changes only when `done` pulses at the end of a reset command.
- R4: A write-bit command (`cmd_op`=3) with `cmd_data[0]`=1 sends 0xFF at the fast rate. Only the start bit is low, which gives one low pulse of 16*DIV_FAST clocks.
- R5: A write-bit command with `cmd_data[0]`=0 sends 0x00 at the fast rate, which gives one low pulse of 9 fast bit times.
- R6: A read-byte command (`cmd_op`=2) sends eight 0xFF frames. A bit decodes as 1 only if its looped-back frame equals 0xFF, and the eight bits are assembled LSB first into `rd_data`.
- R7: A write-byte command (`cmd_op`=1) sends eight frames, bit 0 of `cmd_data` first, each frame 0xFF for a one and 0x00 for a zero.
- R8: The block can only pull the bus low. `bus_drive_low` is 0 whenever the block is not busy.
- R9: `busy` rises on an accepted `cmd_start` and stays high until the last frame has been both fully sent and fully received. `done` pulses for one cycle as `busy` falls. A `cmd_start` that arrives while `busy` is high is ignored.
- R10: `frame_err` shows, from the `done` of a command until the next `done`, whether any frame of that command had its stop bit sampled low.
- R11: The rate goes back from slow to fast only while the bus is released, after the reset frame has been received. A data slot that directly follows a reset runs at the fast rate.
- R12: After reset, `busy`, `done`, `presence`, `frame_err` and `bus_drive_low` are 0 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Starts a command when the block is idle |
| cmd_op | input | 2 | 0 reset/presence, 1 write byte, 2 read byte, 3 write bit |
| cmd_data | input | 8 | Byte to write; bit 0 is the bit for write-bit |
| bus_drive_low | output | 1 | 1 pulls the shared bus low, 0 releases it |
| bus_in | input | 1 | Level of the shared bus |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when a command finishes |
| presence | output | 1 | A device answered the last reset |
| rd_data | output | 8 | Byte assembled by the last read-byte command |
| frame_err | output | 1 | A stop bit was sampled low during the last command |

## Verification
The bench measures the length of every low pulse on the bus. This exposes a reset sent at the fast rate, a write slot left at the slow rate after a reset, bit order reversed in a written byte, and a data-0 slot that releases the bus early. It also plays a device that answers resets and pulls read slots low. A decoder that tested only one bit, or that filled `rd_data` MSB first, returns the wrong byte, and a presence compare that was inverted reports a device where there is none. Further tests start a command while the block is busy, which a block that accepted it would show as an extra slot. A device that holds the line through the stop bit must set `frame_err`, and the next clean command must clear it again.

// File: rtl/owfm_pkg.sv
package owfm_pkg;
   localparam int SLOT_BITS  = 8;
   localparam int FRAME_BITS = SLOT_BITS + 2;

   typedef enum logic [1:0] {
      OP_RESET = 2'd0,
      OP_WBYTE = 2'd1,
      OP_RBYTE = 2'd2,
      OP_WBIT  = 2'd3
   } owfm_op_e;

   localparam logic [SLOT_BITS-1:0] RESET_PATTERN = 8'hF0;
   localparam logic [SLOT_BITS-1:0] SLOT_ONE      = 8'hFF;
   localparam logic [SLOT_BITS-1:0] SLOT_ZERO     = 8'h00;
endpackage

// File: rtl/owfm_tick.sv
module owfm_tick #(
   parameter int DIV_FAST = 54,
   parameter int DIV_SLOW = 651
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow,
   input  logic clr,
   output logic tick
);
   localparam int CW = $clog2(DIV_SLOW + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim  = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
   assign tick = (cnt == lim) && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/owfm_tx.sv
module owfm_tx
   import owfm_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic [SLOT_BITS-1:0] din,
   input  logic                 tick,
   output logic                 active,
   output logic                 line
);
   localparam int SW = $clog2(OVS);
   localparam int BW = $clog2(FRAME_BITS);

   logic [SW-1:0]        sub;
   logic [BW-1:0]        bitn;
   logic [SLOT_BITS:0]   sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         line   <= 1'b1;
         sub    <= '0;
         bitn   <= '0;
         sh     <= '1;
      end else if (go) begin
         active <= 1'b1;
         line   <= 1'b0;
         sub    <= '0;
         bitn   <= '0;
         sh     <= {1'b1, din};
      end else if (active && tick) begin
         if (sub == SW'(OVS - 1)) begin
            sub <= '0;
            if (bitn == BW'(FRAME_BITS - 1)) begin
               active <= 1'b0;
               line   <= 1'b1;
            end else begin
               line <= sh[0];
               sh   <= {1'b1, sh[SLOT_BITS:1]};
               bitn <= bitn + 1'b1;
            end
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end
endmodule

// File: rtl/owfm_rx.sv
module owfm_rx
   import owfm_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arm,
   input  logic                 tick,
   input  logic                 bus_in,
   output logic                 done,
   output logic [SLOT_BITS-1:0] data,
   output logic                 ferr
);
   localparam int SW   = $clog2(OVS);
   localparam int HALF = OVS / 2;
   localparam int NW   = $clog2(SLOT_BITS);

   typedef enum logic [2:0] {RX_OFF, RX_HUNT, RX_START, RX_DATA, RX_STOP} rx_st_e;

   rx_st_e               st;
   logic [SW-1:0]        sub;
   logic [NW-1:0]        nbit;
   logic [SLOT_BITS-1:0] sh;
   logic                 rs;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rs = bus_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[SYNC_STAGES-1:0], bus_in} >> 0;
         end
         assign rs = sr[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RX_OFF;
         sub  <= '0;
         nbit <= '0;
         sh   <= '0;
         done <= 1'b0;
         data <= '0;
         ferr <= 1'b0;
      end else begin
         done <= 1'b0;
         if (arm) begin
            st <= RX_HUNT;
         end else begin
            case (st)
               RX_HUNT: if (tick && !rs) begin
                  st  <= RX_START;
                  sub <= '0;
               end
               RX_START: if (tick) begin
                  if (sub == SW'(HALF - 1)) begin
                     sub  <= '0;
                     nbit <= '0;
                     st   <= rs ? RX_HUNT : RX_DATA;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
               RX_DATA: if (tick) begin
                  if (sub == SW'(OVS - 1)) begin
                     sub <= '0;
                     sh  <= {rs, sh[SLOT_BITS-1:1]};
                     if (nbit == NW'(SLOT_BITS - 1)) st <= RX_STOP;
                     else                            nbit <= nbit + 1'b1;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
               RX_STOP: if (tick) begin
                  if (sub == SW'(OVS - 1)) begin
                     sub  <= '0;
                     st   <= RX_OFF;
                     done <= 1'b1;
                     data <= sh;
                     ferr <= !rs;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
               default: st <= RX_OFF;
            endcase
         end
      end
   end
endmodule

// File: rtl/owfm_seq.sv
module owfm_seq
   import owfm_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_start,
   input  owfm_op_e             cmd_op,
   input  logic [SLOT_BITS-1:0] cmd_data,
   input  logic                 tx_active,
   input  logic                 rx_done,
   input  logic [SLOT_BITS-1:0] rx_data,
   input  logic                 rx_ferr,
   output logic                 tx_go,
   output logic [SLOT_BITS-1:0] tx_val,
   output logic                 rate_slow,
   output logic                 busy,
   output logic                 done,
   output logic                 presence,
   output logic                 frame_err,
   output logic [SLOT_BITS-1:0] rd_data
);
   localparam int LW = $clog2(SLOT_BITS + 1);

   typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT} seq_st_e;

   seq_st_e              st;
   owfm_op_e             op_q;
   logic [SLOT_BITS-1:0] sh;
   logic [SLOT_BITS-1:0] acc;
   logic [SLOT_BITS-1:0] got_byte;
   logic [LW-1:0]        left;
   logic                 got;
   logic                 ferr_acc;
   logic                 slot_one;
   logic                 slot_end;
   logic [SLOT_BITS-1:0] acc_nxt;

   assign tx_go    = (st == S_LAUNCH);
   assign tx_val   = (op_q == OP_RESET) ? RESET_PATTERN : (sh[0] ? SLOT_ONE : SLOT_ZERO);
   assign slot_one = (got_byte == SLOT_ONE);
   assign slot_end = (st == S_WAIT) && got && !tx_active;
   assign acc_nxt  = {slot_one, acc[SLOT_BITS-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         op_q      <= OP_RESET;
         sh        <= '0;
         acc       <= '0;
         got_byte  <= '0;
         left      <= '0;
         got       <= 1'b0;
         ferr_acc  <= 1'b0;
         rate_slow <= 1'b0;
         busy      <= 1'b0;
         done      <= 1'b0;
         presence  <= 1'b0;
         frame_err <= 1'b0;
         rd_data   <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            S_IDLE: if (cmd_start) begin
               op_q     <= cmd_op;
               busy     <= 1'b1;
               ferr_acc <= 1'b0;
               st       <= S_LAUNCH;
               case (cmd_op)
                  OP_RESET: begin
                     rate_slow <= 1'b1;
                     left      <= LW'(1);
                     sh        <= RESET_PATTERN;
                  end
                  OP_WBYTE: begin
                     left <= LW'(SLOT_BITS);
                     sh   <= cmd_data;
                  end
                  OP_RBYTE: begin
                     left <= LW'(SLOT_BITS);
                     sh   <= SLOT_ONE;
                  end
                  default: begin
                     left <= LW'(1);
                     sh   <= cmd_data;
                  end
               endcase
            end
            S_LAUNCH: begin
               got <= 1'b0;
               st  <= S_WAIT;
            end
            S_WAIT: begin
               if (rx_done) begin
                  got      <= 1'b1;
                  got_byte <= rx_data;
                  ferr_acc <= ferr_acc | rx_ferr;
               end
               if (slot_end) begin
                  acc  <= acc_nxt;
                  sh   <= {1'b1, sh[SLOT_BITS-1:1]};
                  left <= left - 1'b1;
                  if (op_q == OP_RESET) begin
                     rate_slow <= 1'b0;
                     presence  <= (got_byte != RESET_PATTERN);
                  end
                  if (left == LW'(1)) begin
                     st        <= S_IDLE;
                     busy      <= 1'b0;
                     done      <= 1'b1;
                     frame_err <= ferr_acc;
                     if (op_q == OP_RBYTE) rd_data <= acc_nxt;
                  end else begin
                     st <= S_LAUNCH;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/owfm_master.sv
module owfm_master
   import owfm_pkg::*;
#(
   parameter int DIV_FAST    = 54,
   parameter int DIV_SLOW    = 651,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_start,
   input  logic [1:0] cmd_op,
   input  logic [7:0] cmd_data,
   output logic       bus_drive_low,
   input  logic       bus_in,
   output logic       busy,
   output logic       done,
   output logic       presence,
   output logic [7:0] rd_data,
   output logic       frame_err
);
   generate
      if (DIV_FAST < 1) begin : g_bad_fast
         $error("DIV_FAST must be at least 1");
      end
      if (DIV_SLOW <= DIV_FAST) begin : g_bad_slow
         $error("DIV_SLOW must exceed DIV_FAST");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic                 tick;
   logic                 tx_go;
   logic [SLOT_BITS-1:0] tx_val;
   logic                 tx_active;
   logic                 tx_line;
   logic                 rx_done;
   logic [SLOT_BITS-1:0] rx_data;
   logic                 rx_ferr;
   logic                 rate_slow;

   assign bus_drive_low = !tx_line;

   owfm_tick #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
      .clk(clk), .rst_n(rst_n), .slow(rate_slow), .clr(tx_go), .tick(tick)
   );

   owfm_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .go(tx_go), .din(tx_val), .tick(tick),
      .active(tx_active), .line(tx_line)
   );

   owfm_rx #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .arm(tx_go), .tick(tick), .bus_in(bus_in),
      .done(rx_done), .data(rx_data), .ferr(rx_ferr)
   );

   owfm_seq u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(owfm_op_e'(cmd_op)),
      .cmd_data(cmd_data), .tx_active(tx_active), .rx_done(rx_done),
      .rx_data(rx_data), .rx_ferr(rx_ferr), .tx_go(tx_go), .tx_val(tx_val),
      .rate_slow(rate_slow), .busy(busy), .done(done), .presence(presence),
      .frame_err(frame_err), .rd_data(rd_data)
   );
endmodule

// File: rtl/owfm_chk.sv
module owfm_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic bus_drive_low,
   input logic presence,
   input logic frame_err,
   input logic rate_slow
);
   // R8
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_drive_low);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3
   presence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(presence) |-> done);

   // R10
   ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_err) |-> done);

   // R11
   rate_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rate_slow) |-> !bus_drive_low);

   // R2
   rate_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rate_slow) |-> busy);
endmodule

bind owfm_master owfm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .bus_drive_low(bus_drive_low), .presence(presence),
   .frame_err(frame_err), .rate_slow(rate_slow)
);

// File: tb/owfm_master_tb.sv
module owfm_master_tb;
   localparam int DF = 2;
   localparam int DS = 24;
   localparam int FBIT = 16 * DF;
   localparam int SBIT = 16 * DS;
   localparam logic [7:0] VEC [0:5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_start = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [7:0] cmd_data = 8'd0;
   logic       bus_drive_low, bus_in, busy, done, presence, frame_err;
   logic [7:0] rd_data;

   int total = 0;
   int bad = 0;
   int mode = 0;
   int pull_cnt = 0;
   int sidx = 0;
   logic [7:0] slave_byte = 8'h00;
   logic dl_q = 1'b0;
   int lowcnt = 0;
   int nw = 0;
   int widths [0:63];
   bit finished = 0;

   always #5 clk = ~clk;

   assign bus_in = !(bus_drive_low || (pull_cnt != 0));

   owfm_master #(.DIV_FAST(DF), .DIV_SLOW(DS)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .bus_drive_low(bus_drive_low), .bus_in(bus_in),
      .busy(busy), .done(done), .presence(presence), .rd_data(rd_data),
      .frame_err(frame_err)
   );

   // device model and low-pulse monitor
   always @(negedge clk) begin
      if (pull_cnt > 0) pull_cnt = pull_cnt - 1;
      if (mode == 1 && !bus_drive_low && dl_q) pull_cnt = 600;
      if (mode == 2 && bus_drive_low && !dl_q) begin
         if (!slave_byte[sidx]) pull_cnt = 150;
         sidx = sidx + 1;
      end
      if (mode == 3 && bus_drive_low && !dl_q) pull_cnt = 400;
      dl_q = bus_drive_low;
      if (bus_drive_low) lowcnt = lowcnt + 1;
      else if (lowcnt != 0) begin
         if (nw < 64) widths[nw] = lowcnt;
         nw = nw + 1;
         lowcnt = 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_w(input int idx, input int exp, input string tag);
      int a;
      a = (idx < nw) ? widths[idx] : -1;
      chk((a >= exp - 2) && (a <= exp + 2), tag, a, exp);
   endtask

   task automatic issue(input logic [1:0] op, input logic [7:0] d);
      @(negedge clk);
      cmd_op = op; cmd_data = d; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(!busy && !done, "R12 busy/done", {busy, done}, 0);
      chk(!presence && !frame_err, "R12 presence/frame_err", {presence, frame_err}, 0);
      chk(rd_data == 8'h00, "R12 rd_data", rd_data, 0);
      chk(!bus_drive_low, "R8 bus released at idle", bus_drive_low, 0);

      // R2 / R3 reset with no device answering
      mode = 0; nw = 0;
      issue(2'd0, 8'h00); wait_done();
      chk(nw == 1, "R2 reset one low pulse", nw, 1);
      chk_w(0, 5 * SBIT, "R2 reset low width");
      chk(!presence, "R3 no device", presence, 0);
      chk(!frame_err, "R10 clean reset frame", frame_err, 0);

      // R3 reset with device answering
      mode = 1;
      issue(2'd0, 8'h00); wait_done();
      mode = 0;
      chk(presence, "R3 device present", presence, 1);

      // R11 / R4 write 1 right after reset runs fast
      nw = 0;
      issue(2'd3, 8'h01); wait_done();
      chk(nw == 1, "R4 write1 pulses", nw, 1);
      chk_w(0, FBIT, "R11 R4 write1 fast start bit");

      // R5 / R1 write 0
      nw = 0;
      issue(2'd3, 8'h00); wait_done();
      chk_w(0, 9 * FBIT, "R5 R1 write0 low nine bits");
      chk(presence, "R3 presence held over write", presence, 1);

      // table walk: write byte then read byte
      foreach (VEC[i]) begin
         nw = 0;
         issue(2'd1, VEC[i]); wait_done();
         chk(nw == 8, "R7 write byte slot count", nw, 8);
         for (int b = 0; b < 8; b++)
            chk_w(b, VEC[i][b] ? FBIT : 9 * FBIT, "R7 R1 write byte slot LSB first");
         slave_byte = VEC[i]; sidx = 0; mode = 2;
         issue(2'd2, 8'h00); wait_done();
         mode = 0;
         chk(rd_data == VEC[i], "R6 read byte", rd_data, VEC[i]);
         chk(!frame_err, "R10 no error on read", frame_err, 0);
      end

      // R9 busy and ignored start
      nw = 0;
      issue(2'd3, 8'h00);
      repeat (50) @(negedge clk);
      chk(busy, "R9 busy during slot", busy, 1);
      issue(2'd0, 8'h00);
      wait_done();
      repeat (100) @(negedge clk);
      chk(nw == 1, "R9 start while busy ignored", nw, 1);
      chk_w(0, 9 * FBIT, "R9 slot unchanged");
      chk(!busy, "R9 idle after done", busy, 0);

      // R10 stop bit held low
      mode = 3;
      issue(2'd3, 8'h01); wait_done();
      mode = 0;
      chk(frame_err, "R10 stop bit low flagged", frame_err, 1);
      repeat (500) @(negedge clk);
      chk(frame_err, "R10 flag held between commands", frame_err, 1);
      issue(2'd3, 8'h01); wait_done();
      chk(!frame_err, "R10 cleared by clean command", frame_err, 0);

      // R3 presence clears on an unanswered reset
      issue(2'd0, 8'h00); wait_done();
      chk(!presence, "R3 presence cleared", presence, 0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule